// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four shared, level-sensitive PCI interrupt lines (A, B, C, D) and steers each one onto one of sixteen legacy interrupt controller inputs. Every line has a byte-wide steering register, and software writes these registers through a byte-enabled write port. A steering value from 0 to 15 names the legacy input for that line. A value of 16 or more parks the line, so its level reaches no output. Several lines may share one legacy input. That input is then the OR of all the lines steered onto it.

Internally the block keeps a 64-bit level map with one bit for each (legacy input, line) pair. During normal operation it refreshes only the bit at each line's current target. Any write that lands on a steering byte clears the whole map and fills it again from the new steering values and the present line levels. This drops stale levels at a line's old target in the same cycle. Each legacy output is the OR of its four map bits.

A small combinational helper is also included. It turns a device/function number and an INTx pin into the shared line that a device in that slot drives. The block plugs between the PCI interrupt wiring and a pair of cascaded legacy controllers. Software sets up its steering registers during platform initialisation.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, each of the four steering bytes reads back 0x80 and all sixteen `legacy_irq` outputs are low.
- R2: Each steering byte has a fixed byte address: line A at 0x60, B at 0x61, C at 0x62 and D at 0x63. When `wr_en` is high, for each lane i with `wr_be[i]` set, data byte `wr_data[8i+7:8i]` is written to byte address `wr_offset+i`. For each lane i, `rd_data[8i+7:8i]` is the byte at address `rd_offset+i`, or 0 if that address holds no steering byte.
- R3: A write leaves every steering byte unchanged, and leaves the outputs unchanged, when none of its enabled lanes addresses 0x60 to 0x63. This covers other offsets and an all-zero byte-enable mask.
- R4: Legacy output k is high when at least one line steered to value k is high. Lines that share a target combine as an OR.
- R5: A steering value of 16 or more (for example 0x10, 0x80 or 0xFF) routes the line nowhere, so its level drives no output. The value 15 routes to output 15.
- R6: After a write to a steering byte, the line's old target no longer carries that line's level. The new target reflects the line's current level. This holds even when the level changes in the same cycle as the write.
- R7: Outputs come from registered state. A change of line level or a steering write seen at a clock edge shows on `legacy_irq` after that edge, never before it.
- R8: The combinational helper output `hlp_line` equals (intx + slot − 1) mod 4, where slot = `hlp_devfn[7:3]` and intx is 0 to 3 for INTA to INTD. Slot 0 therefore yields (intx + 3) mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_offset | input | 8 | Byte address of write lane 0 |
| wr_be | input | 4 | Per-lane write enables |
| wr_data | input | 32 | Write data, lane i in bits 8i+7:8i |
| rd_offset | input | 8 | Byte address of read lane 0 |
| rd_data | output | 32 | Combinational readback of four bytes |
| pirq_level | input | 4 | Levels of shared lines A (bit 0) to D (bit 3) |
| legacy_irq | output | 16 | Levels driven to legacy controller inputs 0 to 15 |
| hlp_devfn | input | 8 | Device/function number for the slot helper |
| hlp_intx | input | 2 | INTx pin for the slot helper (0 = INTA) |
| hlp_line | output | 2 | Shared line chosen by the slot helper |

## Verification
The hardest case to reach from the ports is a steering write that arrives in the same cycle as a level change on the line being moved. A wrong rebuild would leave the old target lit for one cycle, or pick up the stale level. The stimulus first lights a line on one target and then, in a single cycle, rewrites its steering byte and changes the levels. It also uses unaligned, partially enabled writes that straddle the low edge of the steering bytes. Sharing and the 15/16 boundary are covered by steering all lines onto one input and by parking one line at exactly 0x10.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int PIRQ_LINES    = 4;
  localparam int LEGACY_INPUTS = 16;
  localparam int BUS_LANES     = 4;
  localparam int BYTE_W        = 8;

  // bit position of (target, line) inside the flat level map
  function automatic int track_index(input int target, input int line, input int lines);
    return target * lines + line;
  endfunction

  // true when a steering byte selects a real legacy input
  function automatic bit is_routed(input logic [BYTE_W-1:0] value, input int targets);
    return int'(value) < targets;
  endfunction

  // shared line used by a device slot: (intx + slot - 1) mod 4
  function automatic logic [1:0] slot_line(input logic [7:0] devfn, input logic [1:0] intx);
    logic [4:0] slot;
    logic [4:0] sum;
    slot = devfn[7:3];
    sum  = {3'b000, intx} + slot - 5'd1;
    return sum[1:0];
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
  parameter int          N_LINES   = pirq_pkg::PIRQ_LINES,
  parameter logic [7:0]  BASE      = 8'h60,
  parameter logic [7:0]  RESET_VAL = 8'h80
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [7:0]                             wr_offset,
  input  logic [pirq_pkg::BUS_LANES-1:0]         wr_be,
  input  logic [pirq_pkg::BUS_LANES*8-1:0]       wr_data,
  input  logic [7:0]                             rd_offset,
  output logic [pirq_pkg::BUS_LANES*8-1:0]       rd_data,
  output logic [N_LINES-1:0][7:0]                route_q,
  output logic [N_LINES-1:0][7:0]                route_d,
  output logic                                   route_hit
);

  localparam int LANES = pirq_pkg::BUS_LANES;

  // next steering values and the rebuild trigger
  always_comb begin
    route_d   = route_q;
    route_hit = 1'b0;
    for (int j = 0; j < N_LINES; j++) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_en && wr_be[i] && ((wr_offset + 8'(i)) == (BASE + 8'(j)))) begin
          route_d[j] = wr_data[8*i +: 8];
          route_hit  = 1'b1;
        end
      end
    end
  end

  // readback lanes
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < N_LINES; j++) begin
        if ((rd_offset + 8'(i)) == (BASE + 8'(j))) begin
          rd_data[8*i +: 8] = route_q[j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N_LINES; j++) route_q[j] <= RESET_VAL;
    end else begin
      route_q <= route_d;
    end
  end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
  parameter int N_LINES   = pirq_pkg::PIRQ_LINES,
  parameter int N_TARGETS = pirq_pkg::LEGACY_INPUTS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rebuild,
  input  logic [N_LINES-1:0][7:0]        route_q,
  input  logic [N_LINES-1:0][7:0]        route_d,
  input  logic [N_LINES-1:0]             level,
  output logic [N_LINES*N_TARGETS-1:0]   map_q
);

  localparam int MAP_BITS = N_LINES * N_TARGETS;
  localparam int IDX_W    = $clog2(MAP_BITS);

  logic [N_LINES-1:0][7:0]  route_sel;
  logic [MAP_BITS-1:0]      map_d;

  // a rebuild works from the values being written this cycle
  assign route_sel = rebuild ? route_d : route_q;

  always_comb begin
    map_d = rebuild ? '0 : map_q;
    for (int l = 0; l < N_LINES; l++) begin
      if (pirq_pkg::is_routed(route_sel[l], N_TARGETS)) begin
        map_d[IDX_W'(pirq_pkg::track_index(int'(route_sel[l]), l, N_LINES))] = level[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

endmodule

// File: rtl/pirq_out_or.sv
module pirq_out_or #(
  parameter int N_LINES   = pirq_pkg::PIRQ_LINES,
  parameter int N_TARGETS = pirq_pkg::LEGACY_INPUTS
) (
  input  logic [N_LINES*N_TARGETS-1:0] map_q,
  output logic [N_TARGETS-1:0]         irq_out
);

  for (genvar t = 0; t < N_TARGETS; t++) begin : g_tgt
    assign irq_out[t] = |map_q[t*N_LINES +: N_LINES];
  end

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map (
  input  logic [7:0] devfn,
  input  logic [1:0] intx,
  output logic [1:0] line
);

  assign line = pirq_pkg::slot_line(devfn, intx);

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int         N_LINES     = pirq_pkg::PIRQ_LINES,
  parameter int         N_TARGETS   = pirq_pkg::LEGACY_INPUTS,
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  parameter logic [7:0] ROUTE_RESET = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_offset,
  input  logic [3:0]             wr_be,
  input  logic [31:0]            wr_data,
  input  logic [7:0]             rd_offset,
  output logic [31:0]            rd_data,
  input  logic [N_LINES-1:0]     pirq_level,
  output logic [N_TARGETS-1:0]   legacy_irq,
  input  logic [7:0]             hlp_devfn,
  input  logic [1:0]             hlp_intx,
  output logic [1:0]             hlp_line
);

  // named internal events, visible to the bound checker
  logic [N_LINES-1:0][7:0]          route_q;
  logic [N_LINES-1:0][7:0]          route_d;
  logic                             map_rebuild;
  logic [N_LINES*N_TARGETS-1:0]     map_q;

  pirq_route_regs #(
    .N_LINES   (N_LINES),
    .BASE      (ROUTE_BASE),
    .RESET_VAL (ROUTE_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_offset (wr_offset),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .rd_offset (rd_offset),
    .rd_data   (rd_data),
    .route_q   (route_q),
    .route_d   (route_d),
    .route_hit (map_rebuild)
  );

  pirq_level_map #(
    .N_LINES   (N_LINES),
    .N_TARGETS (N_TARGETS)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rebuild (map_rebuild),
    .route_q (route_q),
    .route_d (route_d),
    .level   (pirq_level),
    .map_q   (map_q)
  );

  pirq_out_or #(
    .N_LINES   (N_LINES),
    .N_TARGETS (N_TARGETS)
  ) u_or (
    .map_q   (map_q),
    .irq_out (legacy_irq)
  );

  pirq_slot_map u_slot (
    .devfn (hlp_devfn),
    .intx  (hlp_intx),
    .line  (hlp_line)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int         N_LINES   = 4,
  parameter int         N_TARGETS = 16,
  parameter logic [7:0] BASE      = 8'h60
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_offset,
  input  logic [3:0]                    wr_be,
  input  logic [N_LINES-1:0]            pirq_level,
  input  logic [N_TARGETS-1:0]          legacy_irq,
  input  logic [N_LINES-1:0][7:0]       route_q,
  input  logic [N_LINES*N_TARGETS-1:0]  map_q
);

  logic                                no_touch;
  logic [N_LINES-1:0][N_TARGETS-1:0]   col;

  always_comb begin
    no_touch = 1'b1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < N_LINES; j++) begin
        if (wr_en && wr_be[i] && ((wr_offset + 8'(i)) == (BASE + 8'(j)))) no_touch = 1'b0;
      end
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_col
    for (genvar t = 0; t < N_TARGETS; t++) begin : g_bit
      assign col[l][t] = map_q[t*N_LINES + l];
    end

    // R6: a line lights at most one target
    a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[l]));

    // R5: a parked line contributes nothing
    a_r5_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(route_q[l]) >= N_TARGETS) |-> (col[l] == '0));
  end

  // R1: outputs are quiet when reset ends
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (legacy_irq == '0));

  // R3: writes that miss the steering bytes keep them
  a_r3_no_touch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    no_touch |=> $stable(route_q));

  // R4: an asserted output needs some line high at the previous edge
  a_r4_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_irq != '0) |-> ($past(pirq_level) != '0));

endmodule

bind pci_irq_router pirq_router_chk #(
  .N_LINES   (N_LINES),
  .N_TARGETS (N_TARGETS),
  .BASE      (ROUTE_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_offset  (wr_offset),
  .wr_be      (wr_be),
  .pirq_level (pirq_level),
  .legacy_irq (legacy_irq),
  .route_q    (route_q),
  .map_q      (map_q)
);

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_offset = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_offset = 8'h60;
  logic [31:0] rd_data;
  logic [3:0]  pirq_level = '0;
  logic [15:0] legacy_irq;
  logic [7:0]  hlp_devfn = '0;
  logic [1:0]  hlp_intx = '0;
  logic [1:0]  hlp_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [7:0]  m_route [4];
  logic [3:0]  m_level;
  logic [15:0] m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset),
    .wr_be(wr_be), .wr_data(wr_data), .rd_offset(rd_offset), .rd_data(rd_data),
    .pirq_level(pirq_level), .legacy_irq(legacy_irq),
    .hlp_devfn(hlp_devfn), .hlp_intx(hlp_intx), .hlp_line(hlp_line)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs: scan each legacy input for lines aimed at it
  function automatic logic [15:0] model_out();
    logic [15:0] o;
    o = '0;
    for (int k = 0; k < 16; k++)
      for (int l = 0; l < 4; l++)
        if (m_route[l] == 8'(k) && m_level[l]) o[k] = 1'b1;
    return o;
  endfunction

  // driver: apply one cycle of stimulus, push the expected result
  task automatic drive(input logic [3:0] lvl, input bit wen, input logic [7:0] off,
                       input logic [3:0] be, input logic [31:0] data, input string tag);
    @(negedge clk);
    pirq_level = lvl;
    wr_en      = wen;
    wr_offset  = off;
    wr_be      = be;
    wr_data    = data;
    m_level    = lvl;
    if (wen)
      for (int i = 0; i < 4; i++) begin
        logic [7:0] a;
        a = off + 8'(i);
        if (be[i] && a >= 8'h60 && a <= 8'h63) m_route[a - 8'h60] = data[8*i +: 8];
      end
    #1;
    check(legacy_irq == m_prev, {"R7 before edge: ", tag}, 32'(legacy_irq), 32'(m_prev));
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_prev = model_out();
    sbq.push_back('{exp: m_prev, tag: tag});
  endtask

  task automatic readback(input logic [7:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_offset = off;
    #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  // monitor: compare against the scoreboard away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(legacy_irq == it.exp, it.tag, 32'(legacy_irq), 32'(it.exp));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++) m_route[l] = 8'h80;
    m_level = '0;
    m_prev  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(legacy_irq == 16'h0, "R1 outputs low after reset", 32'(legacy_irq), 32'h0);
    readback(8'h60, 32'h80808080, "R1 steering bytes reset to 0x80");

    // parked lines with all levels high
    drive(4'hF, 1'b0, 8'h00, 4'h0, 32'h0, "R5 reset-parked lines drive nothing");

    // full write: A->5 B->9 C->10 D->11
    drive(4'hF, 1'b1, 8'h60, 4'hF, 32'h0B0A0905, "R4 four lines on four targets");
    readback(8'h60, 32'h0B0A0905, "R2 full write readback");

    // single lane at 0x61 moves B to 3
    drive(4'hF, 1'b1, 8'h61, 4'h1, 32'h00000003, "R6 B moves from 9 to 3");
    readback(8'h60, 32'h0B0A0305, "R2 single lane write at 0x61");

    // unaligned write straddling 0x60: lanes 2,3 -> A=0x0D, B=0x0C
    drive(4'hF, 1'b1, 8'h5E, 4'hC, 32'h0C0D0000, "R2 straddling write outputs");
    readback(8'h60, 32'h0B0A0C0D, "R2 straddling write readback");
    readback(8'h62, 32'h00000B0A, "R2 readback lanes past the steering bytes read 0");

    // sharing: all to 7
    drive(4'h0, 1'b1, 8'h60, 4'hF, 32'h07070707, "R4 shared target idle");
    drive(4'h1, 1'b0, 8'h00, 4'h0, 32'h0, "R4 shared target from A");
    drive(4'h8, 1'b0, 8'h00, 4'h0, 32'h0, "R4 shared target from D");
    drive(4'h9, 1'b0, 8'h00, 4'h0, 32'h0, "R4 shared target from A and D");
    drive(4'h0, 1'b0, 8'h00, 4'h0, 32'h0, "R4 shared target released");

    // boundary: A=15, B=16, C=D=10
    drive(4'h0, 1'b1, 8'h60, 4'hF, 32'h0A0A100F, "R5 boundary setup");
    drive(4'h2, 1'b0, 8'h00, 4'h0, 32'h0, "R5 value 0x10 parks line B");
    drive(4'h1, 1'b0, 8'h00, 4'h0, 32'h0, "R5 value 15 reaches output 15");
    drive(4'hC, 1'b0, 8'h00, 4'h0, 32'h0, "R4 C and D share output 10");

    // writes that miss the steering bytes
    drive(4'hC, 1'b1, 8'h64, 4'hF, 32'h01010101, "R3 write at 0x64 ignored");
    drive(4'hC, 1'b1, 8'h5C, 4'hF, 32'h02020202, "R3 write at 0x5C ignored");
    drive(4'hC, 1'b1, 8'h60, 4'h0, 32'h03030303, "R3 empty byte mask ignored");
    readback(8'h60, 32'h0A0A100F, "R3 steering bytes unchanged");

    // write and level change in one cycle: A -> 2 while only A goes high
    drive(4'h1, 1'b1, 8'h60, 4'h1, 32'h00000002, "R6 rewrite with level change");
    // park D at 0xFF while it is high
    drive(4'h9, 1'b1, 8'h63, 4'h1, 32'h000000FF, "R5 value 0xFF parks line D");
    drive(4'hB, 1'b0, 8'h00, 4'h0, 32'h0, "R7 level rise follows after one edge");
    readback(8'h60, 32'hFF0A1002, "R2 readback after later writes");

    // helper
    for (int n = 0; n < 8; n++) begin
      logic [7:0] dv;
      logic [1:0] ix;
      logic [1:0] ex;
      dv = 8'(n * 37);
      ix = 2'(n);
      ex = 2'(((int'(dv) / 8) + int'(ix) + 3) % 4);
      @(negedge clk);
      hlp_devfn = dv;
      hlp_intx  = ix;
      #1;
      check(hlp_line == ex, "R8 slot helper", 32'(hlp_line), 32'(ex));
    end
    @(negedge clk);
    hlp_devfn = 8'h00;
    hlp_intx  = 2'd0;
    #1;
    check(hlp_line == 2'd3, "R8 slot 0 wraps to line D", 32'(hlp_line), 32'd3);

    repeat (2) @(negedge clk);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule